// File: doc/BRIEF.md
# Planar Adaptive Route Computation Unit

This block picks the next hop for a packet header at one node of a three-dimensional mesh. It compares the node's own coordinates with the packet's destination, takes into account which plane the packet is currently routing in, and reads one congestion flag for each outgoing direction. It returns a one-hot output port, a virtual-channel number and the plane the packet will be in after this hop. The three dimensions form two ordered planes. Plane 0 spans X and Y. Plane 1 spans Y and Z. A packet moves through plane 0 and then plane 1, and it never returns to plane 0.

Within its plane the unit may use either productive direction, so traffic can steer around a hot spot. A packet may not leave plane 0 while its X coordinate is still wrong. Each plane owns its own group of three virtual channels. The group member depends on which dimension is being travelled and on which way the plane's lower dimension still points. This split keeps the channel dependence graph free of cycles.

The result is held in a register behind a two-state handshake, IDLE and HOLD. In IDLE, `in_ready` is high. The **accept** transition (IDLE to HOLD) fires when `in_valid` is seen, and it captures the route. In HOLD, `out_valid` is high and the result is frozen. The **wait** transition (HOLD to HOLD) is taken while `out_ready` is low. The **release** transition (HOLD to IDLE) is taken when `out_ready` is high. While IDLE sees no `in_valid`, it stays in IDLE (the **idle** transition).

Top module: `planar_route_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A header offered with `in_valid` while `in_ready` is high is taken at that clock edge, and `out_valid` rises on the same edge. While `out_valid` is high and `out_ready` is low:
    - `in_ready` is 0;
    - port, channel and plane do not change, even if the inputs change.
  `out_valid` falls at the edge where `out_ready` is seen high.
- R3: `out_port` is one-hot, with these bit positions:
    - bit 0 = +X, bit 1 = -X;
    - bit 2 = +Y, bit 3 = -Y;
    - bit 4 = +Z, bit 5 = -Z;
    - bit 6 = local ejection.
  The congestion input `cong` uses bits 0 to 5 for the same six directions.
- R4: Plane 0 with X unresolved: the X move is chosen. The one exception is when Y is also unresolved, the X port is congested and the Y port is not; in that case the Y move is chosen. `out_plane` stays 0.
- R5: Plane 0 with X resolved: the packet moves to plane 1 (`out_plane` = 1) and is routed by the plane 1 rules.
- R6: In plane 1 the X coordinates are ignored, and `out_port` bits 0 and 1 are never set.
- R7: Plane 1 with both Y and Z unresolved: the Y move is chosen, unless the Y port is congested and the Z port is not. With only one of Y and Z unresolved, that dimension is used whatever the congestion flags say.
- R8: When the plane's active coordinates all match the destination (Y and Z in plane 1), the local port (bit 6) is selected, with channel 3.
- R9: `out_vc` = 3 × plane + sub, where sub is chosen as follows:
    - sub = 0 for a move along the plane's lower dimension (X in plane 0, Y in plane 1);
    - sub = 1 for a move along the upper dimension when the lower-dimension destination is not below the current coordinate;
    - sub = 2 for a move along the upper dimension when it is below.
- R10: `out_plane` is never lower than the plane the header arrived in.
- R11: The move in a dimension is + when the destination coordinate is greater than the current one and - when it is smaller. This holds at the coordinate extremes 0 and 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Unit can take a header (IDLE) |
| cur_x | input | 4 | Node X coordinate |
| cur_y | input | 4 | Node Y coordinate |
| cur_z | input | 4 | Node Z coordinate |
| dst_x | input | 4 | Destination X coordinate |
| dst_y | input | 4 | Destination Y coordinate |
| dst_z | input | 4 | Destination Z coordinate |
| plane_in | input | 1 | Plane the packet is in (0 = X-Y, 1 = Y-Z) |
| cong | input | 6 | Congestion flag per direction port |
| out_valid | output | 1 | Route result held (HOLD) |
| out_ready | input | 1 | Downstream takes the result |
| out_port | output | 7 | One-hot output port |
| out_vc | output | 3 | Virtual-channel number, 0 to 5 |
| out_plane | output | 1 | Plane after this hop |

## Verification
Every result is due one clock edge after acceptance, because a single register sits between the inputs and the outputs. The bench drives inputs on the falling edge, lets one rising edge capture them, and reads port, channel and plane at the next falling edge. Release is checked the same way: `out_valid` must be low at the falling edge after the rising edge at which `out_ready` was high. For the hold test, the inputs are changed while the result waits for `out_ready`, and the outputs are sampled again at each following falling edge.

// File: rtl/pa_route_pkg.sv
package pa_route_pkg;

    localparam int NUM_DIMS     = 3;
    localparam int NUM_DIRS     = 2 * NUM_DIMS;
    localparam int PORT_W       = NUM_DIRS + 1;
    localparam int NUM_PLANES   = 2;
    localparam int VC_PER_PLANE = 3;
    localparam int VC_W         = $clog2(NUM_PLANES * VC_PER_PLANE);

    // dimension indices
    localparam int DIM_X = 0;
    localparam int DIM_Y = 1;
    localparam int DIM_Z = 2;

    // local ejection bit of the one-hot port
    localparam int PORT_LOCAL = NUM_DIRS;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [VC_W-1:0]   vc;
        logic              plane;
    } route_t;

endpackage

// File: rtl/pa_axis_cmp.sv
module pa_axis_cmp #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] cur,
    input  logic [COORD_W-1:0] dst,
    output logic               need,
    output logic               pos
);

    // need: coordinate still differs; pos: travel toward larger values
    always_comb begin
        need = (cur != dst);
        pos  = (dst > cur);
    end

endmodule

// File: rtl/pa_plane_select.sv
module pa_plane_select
    import pa_route_pkg::*;
(
    input  logic [NUM_DIMS-1:0] need,
    input  logic [NUM_DIMS-1:0] pos,
    input  logic                plane_in,
    input  logic [NUM_DIRS-1:0] cong,
    output route_t              route
);

    logic eff_plane;
    int   lo_dim;
    int   hi_dim;
    int   lo_dir;
    int   hi_dir;
    logic lo_need;
    logic hi_need;
    logic lo_busy;
    logic hi_busy;
    logic take_lo;
    logic [VC_W-1:0] vc_base;
    logic [VC_W-1:0] vc_sub;

    always_comb begin
        // leaving plane 0 is only allowed once X is resolved
        eff_plane = plane_in | ~need[DIM_X];
        lo_dim    = eff_plane ? DIM_Y : DIM_X;
        hi_dim    = eff_plane ? DIM_Z : DIM_Y;
        lo_dir    = 2 * lo_dim + (pos[lo_dim] ? 0 : 1);
        hi_dir    = 2 * hi_dim + (pos[hi_dim] ? 0 : 1);
        lo_need   = need[lo_dim];
        hi_need   = need[hi_dim];
        lo_busy   = cong[lo_dir];
        hi_busy   = cong[hi_dir];
        vc_base   = eff_plane ? VC_W'(VC_PER_PLANE) : '0;

        // lower dimension wins ties; upper only when it alone is free
        take_lo   = lo_need && (!hi_need || !(lo_busy && !hi_busy));

        route       = '0;
        route.plane = eff_plane;
        vc_sub      = '0;

        if (!lo_need && !hi_need) begin
            route.port[PORT_LOCAL] = 1'b1;
            vc_sub                 = '0;
        end else if (take_lo) begin
            route.port[lo_dir] = 1'b1;
            vc_sub             = '0;
        end else begin
            route.port[hi_dir] = 1'b1;
            // channel class split by remaining lower-dimension heading
            vc_sub = (lo_need && !pos[lo_dim]) ? VC_W'(2) : VC_W'(1);
        end

        route.vc = vc_base + vc_sub;
    end

endmodule

// File: rtl/pa_route_hold.sv
module pa_route_hold
    import pa_route_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output logic   in_ready,
    input  route_t res_d,
    output logic   out_valid,
    input  logic   out_ready,
    output route_t res_q
);

    hs_state_e state_q;
    hs_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE: if (in_valid)  state_d = HS_HOLD;   // accept
            HS_HOLD: if (out_ready) state_d = HS_IDLE;   // release
            default: state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  res_q <= '0;
        else if (state_q == HS_IDLE && in_valid)     res_q <= res_d;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            HS_IDLE: in_ready  = 1'b1;
            HS_HOLD: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
    end

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_q)));

    a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

endmodule

// File: rtl/planar_route_unit.sv
module planar_route_unit
    import pa_route_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [COORD_W-1:0]  cur_x,
    input  logic [COORD_W-1:0]  cur_y,
    input  logic [COORD_W-1:0]  cur_z,
    input  logic [COORD_W-1:0]  dst_x,
    input  logic [COORD_W-1:0]  dst_y,
    input  logic [COORD_W-1:0]  dst_z,
    input  logic                plane_in,
    input  logic [NUM_DIRS-1:0] cong,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [PORT_W-1:0]   out_port,
    output logic [VC_W-1:0]     out_vc,
    output logic                out_plane
);

    logic [NUM_DIMS-1:0][COORD_W-1:0] cur_v;
    logic [NUM_DIMS-1:0][COORD_W-1:0] dst_v;
    logic [NUM_DIMS-1:0]              need;
    logic [NUM_DIMS-1:0]              pos;
    route_t                           route_d;
    route_t                           route_q;

    assign cur_v = {cur_z, cur_y, cur_x};
    assign dst_v = {dst_z, dst_y, dst_x};

    for (genvar d = 0; d < NUM_DIMS; d++) begin : g_axis
        pa_axis_cmp #(.COORD_W(COORD_W)) u_cmp (
            .cur  (cur_v[d]),
            .dst  (dst_v[d]),
            .need (need[d]),
            .pos  (pos[d])
        );
    end

    pa_plane_select u_sel (
        .need     (need),
        .pos      (pos),
        .plane_in (plane_in),
        .cong     (cong),
        .route    (route_d)
    );

    pa_route_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .res_d     (route_d),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .res_q     (route_q)
    );

    assign out_port  = route_q.port;
    assign out_vc    = route_q.vc;
    assign out_plane = route_q.plane;

    a_r3_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_port) == 1));

    a_r6_no_x_in_plane1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_plane) |-> (out_port[1:0] == 2'b00));

    a_r9_vc_in_plane_group: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_plane ? (out_vc >= VC_W'(VC_PER_PLANE) && out_vc < VC_W'(2*VC_PER_PLANE))
                                 : (out_vc < VC_W'(VC_PER_PLANE))));

    a_r10_plane_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_plane >= $past(plane_in)));

endmodule

// File: tb/planar_route_unit_bench.sv
module planar_route_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic [3:0] cx, cy, cz, dx, dy, dz;
        logic       pl;
        logic [5:0] cg;
        logic [6:0] ep;
        logic [2:0] ev;
        logic       epl;
        logic [3:0] tag;
    } vec_t;

    // cong / port bits: 0 +X, 1 -X, 2 +Y, 3 -Y, 4 +Z, 5 -Z, 6 local
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,4'd1,4'd1, 4'd5,4'd3,4'd2, 1'b0, 6'b000000, 7'h01, 3'd0, 1'b0, 4'd4},
        '{4'd1,4'd1,4'd1, 4'd5,4'd3,4'd2, 1'b0, 6'b000001, 7'h04, 3'd1, 1'b0, 4'd9},
        '{4'd1,4'd1,4'd1, 4'd5,4'd3,4'd2, 1'b0, 6'b000101, 7'h01, 3'd0, 1'b0, 4'd4},
        '{4'd6,4'd2,4'd0, 4'd3,4'd2,4'd9, 1'b0, 6'b000010, 7'h02, 3'd0, 1'b0, 4'd4},
        '{4'd6,4'd5,4'd0, 4'd3,4'd1,4'd0, 1'b0, 6'b000010, 7'h08, 3'd2, 1'b0, 4'd9},
        '{4'd4,4'd1,4'd1, 4'd4,4'd3,4'd7, 1'b0, 6'b000000, 7'h04, 3'd3, 1'b1, 4'd5},
        '{4'd4,4'd1,4'd1, 4'd4,4'd3,4'd7, 1'b0, 6'b000100, 7'h10, 3'd4, 1'b1, 4'd7},
        '{4'd9,4'd8,4'd5, 4'd2,4'd3,4'd1, 1'b1, 6'b001000, 7'h20, 3'd5, 1'b1, 4'd6},
        '{4'd9,4'd4,4'd5, 4'd2,4'd4,4'd1, 1'b1, 6'b100000, 7'h20, 3'd4, 1'b1, 4'd7},
        '{4'd0,4'd4,4'd1, 4'd15,4'd4,4'd1,1'b1, 6'b000000, 7'h40, 3'd3, 1'b1, 4'd8},
        '{4'd7,4'd7,4'd7, 4'd7,4'd7,4'd7, 1'b0, 6'b000000, 7'h40, 3'd3, 1'b1, 4'd10},
        '{4'd0,4'd0,4'd0, 4'd15,4'd0,4'd0,1'b0, 6'b111111, 7'h01, 3'd0, 1'b0, 4'd11},
        '{4'd3,4'd9,4'd2, 4'd3,4'd9,4'd0, 1'b0, 6'b100000, 7'h20, 3'd4, 1'b1, 4'd5}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] cur_x = '0, cur_y = '0, cur_z = '0;
    logic [3:0] dst_x = '0, dst_y = '0, dst_z = '0;
    logic       plane_in = 1'b0;
    logic [5:0] cong = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [6:0] out_port;
    logic [2:0] out_vc;
    logic       out_plane;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    planar_route_unit u_planar_route_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
        .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
        .plane_in(plane_in), .cong(cong),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_vc(out_vc), .out_plane(out_plane)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cur_x = v.cx; cur_y = v.cy; cur_z = v.cz;
        dst_x = v.dx; dst_y = v.dy; dst_z = v.dz;
        plane_in = v.pl; cong = v.cg;
    endtask

    task automatic run_vec(input vec_t v);
        string t;
        t = tag_name(v.tag);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);                 // captured at the rising edge between
        in_valid = 1'b0;
        check("R2", "out_valid after accept", {7'd0, out_valid}, 8'd1);
        check(t, "port (R3 encoding)", {1'b0, out_port}, {1'b0, v.ep});
        check(t, "vc", {5'd0, out_vc}, {5'd0, v.ev});
        check(t, "plane", {7'd0, out_plane}, {7'd0, v.epl});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R2", "out_valid after release", {7'd0, out_valid}, 8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "out_valid in reset", {7'd0, out_valid}, 8'd0);
        check("R1", "in_ready in reset", {7'd0, in_ready}, 8'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", {7'd0, out_valid}, 8'd0);
        check("R1", "in_ready after reset", {7'd0, in_ready}, 8'd1);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R2: result held while downstream stalls, inputs changed meanwhile
        @(negedge clk);
        drive(VECS[0]);
        in_valid = 1'b1;
        @(negedge clk);
        drive(VECS[7]);                 // would give -Z if re-sampled
        for (int k = 0; k < 3; k++) begin
            check("R2", "held valid", {7'd0, out_valid}, 8'd1);
            check("R2", "in_ready low in hold", {7'd0, in_ready}, 8'd0);
            check("R2", "held port", {1'b0, out_port}, 8'h01);
            check("R2", "held vc", {5'd0, out_vc}, 8'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R2", "released", {7'd0, out_valid}, 8'd0);
        check("R2", "ready again", {7'd0, in_ready}, 8'd1);

        // R11: minus move at the lower extreme
        run_vec('{4'd15,4'd3,4'd3, 4'd0,4'd3,4'd3, 1'b0, 6'b000000, 7'h02, 3'd0, 1'b0, 4'd11});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule